// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block drives the control side of one SDRAM device: clock enable, chip select, RAS, CAS, WE, the data mask and the address bus. It issues commands from two sources. Three bus masters (a display controller, a DMA engine and a CPU) raise level requests. Each granted request becomes a fixed sequence: activate, a fixed gap of NOP cycles, a read or write with auto precharge, then a fixed recovery gap. Software can also push a single command by writing a command code. The block then drives that command's pin pattern for one cycle. Self refresh entry and exit are encoded through the clock-enable level of the previous cycle.

Access length is set only by two parameters, `TRCD_CYC` and `REC_CYC`. No external wait setting changes it. Every pin is registered, so each decision appears on the pins one clock edge after the inputs are sampled.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While `en` is low the pins show deselect: clock enable 1; chip select, RAS, CAS and WE all 1; mask 1; address 0. `busy` is 0. Master requests and command writes made while disabled are dropped and have no later effect.
- R2: While enabled and idle, the block drives NOP: clock enable 1, chip select 0, RAS/CAS/WE 1, mask 1.
- R3: A granted request drives activate (chip select/RAS/CAS/WE = 0/0/1/1, mask 1) on the edge that samples it. The master's row is on the address bus.
- R4: After the activate come exactly `TRCD_CYC` NOP cycles, then one column command: read 0/1/0/1 or write 0/1/0/0, with mask 0. Its address holds the column in the low `COL_W` bits, bit 10 = 1, and all other bits 0.
- R5: `REC_CYC` NOP cycles follow the column command. In the last of them, the granted master's bit of `mst_done` is 1 for one cycle and `busy` is 0. A request present then is granted on the next edge.
- R6: When several masters request at once, bit 0 (display) wins over bit 1 (DMA), which wins over bit 2 (CPU).
- R7: `busy` is 1 from the first command cycle of an access until the completion cycle. A request raised while busy waits.
- R8: Command codes and their pin patterns (clock enable, chip select/RAS/CAS/WE, mask):
  - 1 activate, 1, 0/0/1/1, 1.
  - 2 precharge-all, 1, 0/0/1/0, 1.
  - 3 read and 4 read with auto precharge, 1, 0/1/0/1, 0.
  - 5 write and 6 write with auto precharge, 1, 0/1/0/0, 0.
  - 7 mode register set, 1, 0/0/0/0, 1.
  - 8 burst stop, 1, 0/1/1/0, 1.
  - 9 auto refresh, 1, 0/0/0/1, 1.
  - Each pattern lasts one cycle with `busy` 1, followed by NOP.
- R9: The address for a software command depends on the code:
  - Activate and mode register set drive `sw_addr` unchanged.
  - Read and write drive the low `COL_W` bits of `sw_addr`, with bit 10 at 0 (codes 3, 5) or 1 (codes 4, 6) and the other bits 0.
  - Precharge-all drives only bit 10 high.
  - Burst stop and refresh drive 0.
- R10: A command write that arrives while an access runs is held. It is issued on the first edge after the access completes, ahead of any waiting master request. A later write replaces a held command that has not yet been issued.
- R11: Code 10 (self refresh entry) drives clock enable 0 with chip select/RAS/CAS 0 and WE 1, after a cycle with clock enable 1. After that the pins hold clock enable 0 with all four selects 1 and `busy` 1. Master requests are not granted in this state.
- R12: During self refresh only code 11 acts. It drives clock enable 1 with all four selects 1 for one cycle, then NOP with `busy` 0. Other codes written during self refresh are dropped. Code 11 outside self refresh is dropped, and so are codes 0 and 12 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Global enable |
| mst_req | input | NUM_MST | Level access request per master (bit 0 display, 1 DMA, 2 CPU) |
| mst_wr | input | NUM_MST | 1 = write access, per master |
| mst_row | input | NUM_MST*ADDR_W | Row address per master |
| mst_col | input | NUM_MST*COL_W | Column address per master |
| mst_done | output | NUM_MST | One-cycle completion pulse per master |
| sw_wr | input | 1 | Command write strobe |
| sw_code | input | 4 | Command code |
| sw_addr | input | ADDR_W | Address or mode data for the command |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 1 | Data mask |
| sd_a | output | ADDR_W | SDRAM address bus |
| busy | output | 1 | Sequence, command or self refresh in progress |

## Verification
Inputs are applied on a falling edge. A request or command write shows its first pin pattern after the next rising edge, so the check samples at the falling edge that follows. After an activate, the column command is due `TRCD_CYC`+1 edges later, and the completion pulse `REC_CYC` edges after that. A held command or waiting request goes out one edge after the completion cycle. Every check steps exactly one clock per expected pin change and compares the full pin pattern, the address, `busy` and `mst_done` at that sample.

// File: rtl/sdcs_pkg.sv
// Package: shared types for the SDRAM command sequencer.
// Holds the pin command set, the command codes written by software,
// the sequencer states and the function that maps a pin command to pin levels.
package sdcs_pkg;

    typedef enum logic [3:0] {
        PC_DESL, PC_NOP, PC_ACT, PC_PREA, PC_READ, PC_WRITE,
        PC_MRS, PC_BST, PC_AREF, PC_SRE, PC_SRHOLD, PC_SRX
    } pin_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_GAP, ST_REC, ST_SWC, ST_SREF
    } seq_st_e;

    localparam logic [3:0] SW_ACT  = 4'd1;
    localparam logic [3:0] SW_PREA = 4'd2;
    localparam logic [3:0] SW_RD   = 4'd3;
    localparam logic [3:0] SW_RDA  = 4'd4;
    localparam logic [3:0] SW_WR   = 4'd5;
    localparam logic [3:0] SW_WRA  = 4'd6;
    localparam logic [3:0] SW_MRS  = 4'd7;
    localparam logic [3:0] SW_BST  = 4'd8;
    localparam logic [3:0] SW_AREF = 4'd9;
    localparam logic [3:0] SW_SRE  = 4'd10;
    localparam logic [3:0] SW_SRX  = 4'd11;

    localparam int AP_BIT = 10;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic dqm;
    } ctl_pins_t;

    // Map a pin command to clock enable, selects and mask levels.
    function automatic ctl_pins_t encode(input pin_cmd_e c);
        ctl_pins_t p;
        p = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, dqm: 1'b1};
        case (c)
            PC_DESL:   p.cs_n = 1'b1;
            PC_ACT:    p.ras_n = 1'b0;
            PC_PREA:   begin p.ras_n = 1'b0; p.we_n = 1'b0; end
            PC_READ:   begin p.cas_n = 1'b0; p.dqm = 1'b0; end
            PC_WRITE:  begin p.cas_n = 1'b0; p.we_n = 1'b0; p.dqm = 1'b0; end
            PC_MRS:    begin p.ras_n = 1'b0; p.cas_n = 1'b0; p.we_n = 1'b0; end
            PC_BST:    p.we_n = 1'b0;
            PC_AREF:   begin p.ras_n = 1'b0; p.cas_n = 1'b0; end
            PC_SRE:    begin p.cke = 1'b0; p.ras_n = 1'b0; p.cas_n = 1'b0; end
            PC_SRHOLD: begin p.cke = 1'b0; p.cs_n = 1'b1; end
            PC_SRX:    p.cs_n = 1'b1;
            default:   p = p;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sdcs_arb.sv
// Fixed-priority arbiter: the lowest request index wins.
// Assumes requests are sampled only when the sequencer is idle.
module sdcs_arb #(
    parameter int NUM_MST = 3,
    localparam int IDX_W = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] req,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    logic [NUM_MST:0]   blk;
    logic [NUM_MST-1:0] gnt;

    assign blk[0] = 1'b0;

    // One grant stage per master; a lower index blocks all higher ones.
    for (genvar gi = 0; gi < NUM_MST; gi++) begin : g_stage
        assign gnt[gi]     = req[gi] & ~blk[gi];
        assign blk[gi + 1] = blk[gi] | req[gi];
    end

    assign any = blk[NUM_MST];

    // Turn the one-hot grant into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_MST; i++) begin
            if (gnt[i]) idx = IDX_W'(i);
        end
    end

    // R6: at most one master granted, and only one that requests
    p_gnt_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~req) == '0));

endmodule

// File: rtl/sdcs_swq.sv
// Software command holder: passes a command write straight through
// when the sequencer takes it at once, and otherwise keeps one command
// until it is taken. A newer write replaces the held one. Cleared while disabled.
module sdcs_swq #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [3:0]        code,
    input  logic [ADDR_W-1:0] addr,
    input  logic              take,
    output logic              vld,
    output logic [3:0]        code_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic              pend_q;
    logic [3:0]        code_q;
    logic [ADDR_W-1:0] addr_q;

    // Offer the held command first, otherwise the write of this cycle.
    always_comb begin
        vld    = en && (pend_q || wr);
        code_o = pend_q ? code_q : code;
        addr_o = pend_q ? addr_q : addr;
    end

    // Hold, replace or release the stored command.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pend_q <= 1'b0;
            code_q <= '0;
            addr_q <= '0;
        end else if (wr) begin
            if (pend_q || !take) begin
                pend_q <= 1'b1;
                code_q <= code;
                addr_q <= addr;
            end
        end else if (take) begin
            pend_q <= 1'b0;
        end
    end

    // R10: a held command stays held until taken or replaced
    p_hold_until_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && en && !take && !wr) |=> (pend_q && $stable(code_q)));

endmodule

// File: rtl/sdcs_fsm.sv
// Access and command sequencer.
// Chooses the next pin command every cycle: it grants master accesses
// (activate, tRCD gap, column command with auto precharge, recovery gap),
// issues software commands and tracks self refresh.
// Assumes TRCD_CYC >= 0, REC_CYC >= 1 and COL_W <= 10.
module sdcs_fsm
    import sdcs_pkg::*;
#(
    parameter int NUM_MST  = 3,
    parameter int ADDR_W   = 13,
    parameter int COL_W    = 9,
    parameter int TRCD_CYC = 2,
    parameter int REC_CYC  = 2,
    localparam int IDX_W = (NUM_MST > 1) ? $clog2(NUM_MST) : 1,
    localparam int CMAX  = (TRCD_CYC > REC_CYC) ? TRCD_CYC : REC_CYC,
    localparam int CNT_W = $clog2(CMAX + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [NUM_MST-1:0]        mst_req,
    input  logic [NUM_MST-1:0]        mst_wr,
    input  logic [NUM_MST*ADDR_W-1:0] mst_row,
    input  logic [NUM_MST*COL_W-1:0]  mst_col,
    input  logic                      sw_vld,
    input  logic [3:0]                sw_code,
    input  logic [ADDR_W-1:0]         sw_addr,
    output logic                      sw_take,
    output pin_cmd_e                  nxt_cmd,
    output logic [ADDR_W-1:0]         nxt_addr,
    output logic                      busy,
    output logic [NUM_MST-1:0]        done
);

    seq_st_e            st_q, st_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [IDX_W-1:0]   mst_q;
    logic               wr_q;
    logic [COL_W-1:0]   col_q;
    logic [NUM_MST-1:0] done_q, done_vec;
    logic               load, fin;
    logic [IDX_W-1:0]   gnt_idx;
    logic               gnt_any;

    sdcs_arb #(.NUM_MST(NUM_MST)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (mst_req),
        .idx   (gnt_idx),
        .any   (gnt_any)
    );

    // Build a column address with the auto-precharge bit.
    function automatic logic [ADDR_W-1:0] col_addr(input logic [COL_W-1:0] c, input logic ap);
        logic [ADDR_W-1:0] a;
        a         = '0;
        a[COL_W-1:0] = c;
        a[AP_BIT] = ap;
        return a;
    endfunction

    // Next-state, next pin command and take decisions.
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        nxt_cmd  = PC_NOP;
        nxt_addr = '0;
        sw_take  = 1'b0;
        load     = 1'b0;
        fin      = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (!en) begin
                    nxt_cmd = PC_DESL;
                end else if (sw_vld) begin
                    sw_take = 1'b1;
                    st_d    = ST_SWC;
                    case (sw_code)
                        SW_ACT:  begin nxt_cmd = PC_ACT;   nxt_addr = sw_addr; end
                        SW_PREA: nxt_cmd = PC_PREA;
                        SW_RD:   begin nxt_cmd = PC_READ;  nxt_addr = col_addr(sw_addr[COL_W-1:0], 1'b0); end
                        SW_RDA:  begin nxt_cmd = PC_READ;  nxt_addr = col_addr(sw_addr[COL_W-1:0], 1'b1); end
                        SW_WR:   begin nxt_cmd = PC_WRITE; nxt_addr = col_addr(sw_addr[COL_W-1:0], 1'b0); end
                        SW_WRA:  begin nxt_cmd = PC_WRITE; nxt_addr = col_addr(sw_addr[COL_W-1:0], 1'b1); end
                        SW_MRS:  begin nxt_cmd = PC_MRS;   nxt_addr = sw_addr; end
                        SW_BST:  nxt_cmd = PC_BST;
                        SW_AREF: nxt_cmd = PC_AREF;
                        SW_SRE:  begin nxt_cmd = PC_SRE;   st_d = ST_SREF; end
                        default: st_d = ST_IDLE;
                    endcase
                end else if (gnt_any) begin
                    load     = 1'b1;
                    nxt_cmd  = PC_ACT;
                    nxt_addr = mst_row[int'(gnt_idx)*ADDR_W +: ADDR_W];
                    st_d     = ST_GAP;
                    cnt_d    = CNT_W'(TRCD_CYC);
                end
            end
            ST_GAP: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    nxt_cmd  = wr_q ? PC_WRITE : PC_READ;
                    nxt_addr = col_addr(col_q, 1'b1);
                    st_d     = ST_REC;
                    cnt_d    = CNT_W'(REC_CYC);
                end
            end
            ST_REC: begin
                if (cnt_q == CNT_W'(1)) begin
                    st_d = ST_IDLE;
                    fin  = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_SWC: st_d = ST_IDLE;
            ST_SREF: begin
                nxt_cmd = PC_SRHOLD;
                if (sw_vld) begin
                    sw_take = 1'b1;
                    if (sw_code == SW_SRX) begin
                        nxt_cmd = PC_SRX;
                        st_d    = ST_SWC;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Completion pulse goes to the master captured at grant.
    always_comb begin
        for (int i = 0; i < NUM_MST; i++) begin
            done_vec[i] = fin && (mst_q == IDX_W'(i));
        end
    end

    // State, counter and captured access fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            mst_q  <= '0;
            wr_q   <= 1'b0;
            col_q  <= '0;
            done_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            done_q <= done_vec;
            if (load) begin
                mst_q <= gnt_idx;
                wr_q  <= mst_wr[gnt_idx];
                col_q <= mst_col[int'(gnt_idx)*COL_W +: COL_W];
            end
        end
    end

    assign busy = (st_q != ST_IDLE);
    assign done = done_q;

    // R6: only one master is told of completion at a time
    p_done_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_q));

    // R5: completion coincides with the return to idle
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q != '0) |-> (st_q == ST_IDLE));

    // R11: self refresh is left only through a command cycle
    p_sref_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SREF) |=> (st_q == ST_SREF || st_q == ST_SWC));

    // R7: no new access is loaded unless the sequencer was idle
    p_grant_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GAP && $past(st_q) != ST_GAP) |-> ($past(st_q) == ST_IDLE));

endmodule

// File: rtl/sdcs_pins.sv
// Pin register: turns the next pin command into registered levels on
// clock enable, selects, mask and address. Precharge-all forces bit 10 high.
// Assumes ADDR_W > 10.
module sdcs_pins
    import sdcs_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pin_cmd_e          cmd,
    input  logic [ADDR_W-1:0] addr,
    output ctl_pins_t         pins,
    output logic [ADDR_W-1:0] a
);

    ctl_pins_t         pins_q;
    logic [ADDR_W-1:0] a_q;

    // Register the encoded pins; reset shows deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= encode(PC_DESL);
            a_q    <= '0;
        end else begin
            pins_q <= encode(cmd);
            a_q    <= addr;
            if (cmd == PC_PREA) a_q[AP_BIT] <= 1'b1;
        end
    end

    assign pins = pins_q;
    assign a    = a_q;

    // R11: clock enable only falls with the self refresh entry pattern
    p_cke_fall_sre_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pins_q.cke) |-> (!pins_q.cs_n && !pins_q.ras_n && !pins_q.cas_n && pins_q.we_n));

    // R12: clock enable only rises with all four selects high
    p_cke_rise_desel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins_q.cke) |-> (pins_q.cs_n && pins_q.ras_n && pins_q.cas_n && pins_q.we_n));

    // R4: a low mask is only seen with a column command
    p_dqm_low_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_q.dqm |-> (!pins_q.cs_n && pins_q.ras_n && !pins_q.cas_n && pins_q.cke));

endmodule

// File: rtl/sdram_cmd_seq.sv
// Top of the SDRAM command sequencer: joins the software command holder,
// the sequencer and the pin register. All SDRAM pins are registered.
// Assumes one SDRAM device and level requests from masters.
module sdram_cmd_seq
    import sdcs_pkg::*;
#(
    parameter int NUM_MST  = 3,
    parameter int ADDR_W   = 13,
    parameter int COL_W    = 9,
    parameter int TRCD_CYC = 2,
    parameter int REC_CYC  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [NUM_MST-1:0]        mst_req,
    input  logic [NUM_MST-1:0]        mst_wr,
    input  logic [NUM_MST*ADDR_W-1:0] mst_row,
    input  logic [NUM_MST*COL_W-1:0]  mst_col,
    output logic [NUM_MST-1:0]        mst_done,
    input  logic                      sw_wr,
    input  logic [3:0]                sw_code,
    input  logic [ADDR_W-1:0]         sw_addr,
    output logic                      sd_cke,
    output logic                      sd_cs_n,
    output logic                      sd_ras_n,
    output logic                      sd_cas_n,
    output logic                      sd_we_n,
    output logic                      sd_dqm,
    output logic [ADDR_W-1:0]         sd_a,
    output logic                      busy
);

    logic              q_vld, q_take;
    logic [3:0]        q_code;
    logic [ADDR_W-1:0] q_addr;
    pin_cmd_e          nxt_cmd;
    logic [ADDR_W-1:0] nxt_addr;
    ctl_pins_t         pins;

    sdcs_swq #(.ADDR_W(ADDR_W)) u_swq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .wr     (sw_wr),
        .code   (sw_code),
        .addr   (sw_addr),
        .take   (q_take),
        .vld    (q_vld),
        .code_o (q_code),
        .addr_o (q_addr)
    );

    sdcs_fsm #(
        .NUM_MST  (NUM_MST),
        .ADDR_W   (ADDR_W),
        .COL_W    (COL_W),
        .TRCD_CYC (TRCD_CYC),
        .REC_CYC  (REC_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mst_req  (mst_req),
        .mst_wr   (mst_wr),
        .mst_row  (mst_row),
        .mst_col  (mst_col),
        .sw_vld   (q_vld),
        .sw_code  (q_code),
        .sw_addr  (q_addr),
        .sw_take  (q_take),
        .nxt_cmd  (nxt_cmd),
        .nxt_addr (nxt_addr),
        .busy     (busy),
        .done     (mst_done)
    );

    sdcs_pins #(.ADDR_W(ADDR_W)) u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (nxt_cmd),
        .addr  (nxt_addr),
        .pins  (pins),
        .a     (sd_a)
    );

    assign sd_cke   = pins.cke;
    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;
    assign sd_dqm   = pins.dqm;

    // R1: disabled and idle in one cycle means deselect in the next
    p_disabled_desl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en && !busy) |-> (sd_cs_n && sd_cke && sd_a == '0));

endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;

    localparam int N  = 3;
    localparam int AW = 13;
    localparam int CW = 9;
    localparam int T  = 2;
    localparam int R  = 2;

    // {cke, cs_n, ras_n, cas_n, we_n, dqm}
    localparam logic [5:0] P_DESL = 6'b111111;
    localparam logic [5:0] P_NOP  = 6'b101111;
    localparam logic [5:0] P_ACT  = 6'b100111;
    localparam logic [5:0] P_PREA = 6'b100101;
    localparam logic [5:0] P_RD   = 6'b101010;
    localparam logic [5:0] P_WR   = 6'b101000;
    localparam logic [5:0] P_MRS  = 6'b100001;
    localparam logic [5:0] P_BST  = 6'b101101;
    localparam logic [5:0] P_REF  = 6'b100011;
    localparam logic [5:0] P_SRE  = 6'b000011;
    localparam logic [5:0] P_SRH  = 6'b011111;
    localparam logic [5:0] P_SRX  = 6'b111111;

    // {req[2:0], wr[2:0], expected winner[1:0]}
    localparam logic [7:0] VEC [7] = '{
        8'b001_000_00, 8'b010_010_01, 8'b100_000_10, 8'b111_001_00,
        8'b110_100_01, 8'b101_100_00, 8'b100_100_10
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic [N-1:0]    mst_req = '0;
    logic [N-1:0]    mst_wr = '0;
    logic [N*AW-1:0] mst_row;
    logic [N*CW-1:0] mst_col;
    logic [N-1:0]    mst_done;
    logic            sw_wr = 1'b0;
    logic [3:0]      sw_code = '0;
    logic [AW-1:0]   sw_addr = '0;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, busy;
    logic [AW-1:0]   sd_a;
    logic [5:0]      pins;

    int  total = 0;
    int  bad = 0;
    bit  fin = 1'b0;

    assign pins = {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm};

    sdram_cmd_seq i_sdram_cmd_seq (
        .clk (clk), .rst_n (rst_n), .en (en),
        .mst_req (mst_req), .mst_wr (mst_wr), .mst_row (mst_row), .mst_col (mst_col),
        .mst_done (mst_done), .sw_wr (sw_wr), .sw_code (sw_code), .sw_addr (sw_addr),
        .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n),
        .sd_we_n (sd_we_n), .sd_dqm (sd_dqm), .sd_a (sd_a), .busy (busy)
    );

    function automatic logic [AW-1:0] row_of(input int i);
        return 13'h0A5 + 13'(i) * 13'h321;
    endfunction

    function automatic logic [CW-1:0] col_of(input int i);
        return 9'h013 + 9'(i) * 9'h047;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Checks from the first gap NOP through the completion cycle.
    task automatic tail(input int idx, input bit w, input int gap_left);
        for (int k = 0; k < gap_left; k++) begin
            step();
            chk("R4 gap NOP", 32'(pins), 32'(P_NOP));
        end
        step();
        chk("R4 column pins", 32'(pins), 32'(w ? P_WR : P_RD));
        chk("R4 column address", 32'(sd_a), 32'(13'h400 | 13'(col_of(idx))));
        for (int k = 0; k < R; k++) begin
            step();
            chk("R5 recovery NOP", 32'(pins), 32'(P_NOP));
            if (k == R - 1) begin
                chk("R5 done pulse", 32'(mst_done), 32'(1 << idx));
                chk("R5 busy low at done", 32'(busy), 32'd0);
            end else begin
                chk("R7 busy in recovery", 32'(busy), 32'd1);
            end
        end
    endtask

    task automatic access(input logic [2:0] rq, input logic [2:0] wm, input int idx);
        mst_req = rq;
        mst_wr  = wm;
        step();
        chk("R3 activate pins", 32'(pins), 32'(P_ACT));
        chk("R6 R3 row of winner", 32'(sd_a), 32'(row_of(idx)));
        chk("R7 busy after grant", 32'(busy), 32'd1);
        mst_req = '0;
        tail(idx, wm[idx], T);
        step();
        chk("R5 done one cycle", 32'(mst_done), 32'd0);
    endtask

    task automatic sw_issue(input logic [3:0] c, input logic [5:0] ep, input logic [AW-1:0] ea, input string tag);
        sw_wr   = 1'b1;
        sw_code = c;
        sw_addr = 13'h15A6;
        step();
        sw_wr = 1'b0;
        chk({tag, " pins"}, 32'(pins), 32'(ep));
        chk({"R9 ", tag, " address"}, 32'(sd_a), 32'(ea));
        chk({tag, " busy"}, 32'(busy), 32'd1);
        step();
        chk("R8 NOP after command", 32'(pins), 32'(P_NOP));
        chk("R8 busy clear", 32'(busy), 32'd0);
    endtask

    task automatic drop_code(input logic [3:0] c);
        sw_wr   = 1'b1;
        sw_code = c;
        step();
        sw_wr = 1'b0;
        chk("R12 dropped code pins", 32'(pins), 32'(P_NOP));
        chk("R12 dropped code busy", 32'(busy), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mst_row[i*AW +: AW] = row_of(i);
            mst_col[i*CW +: CW] = col_of(i);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset and disabled state
        chk("R1 reset pins", 32'(pins), 32'(P_DESL));
        chk("R1 reset address", 32'(sd_a), 32'd0);
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset done", 32'(mst_done), 32'd0);
        mst_req = 3'b001;
        sw_wr   = 1'b1;
        sw_code = 4'd9;
        step();
        sw_wr   = 1'b0;
        mst_req = '0;
        chk("R1 disabled ignores inputs", 32'(pins), 32'(P_DESL));
        chk("R1 disabled busy", 32'(busy), 32'd0);
        en = 1'b1;
        step();
        chk("R2 enabled idle NOP", 32'(pins), 32'(P_NOP));
        step();
        chk("R1 dropped write left no trace", 32'(pins), 32'(P_NOP));

        // R3..R7 table of master accesses
        for (int v = 0; v < 7; v++) begin
            access(VEC[v][7:5], VEC[v][4:2], int'(VEC[v][1:0]));
        end

        // R7: request raised while busy waits for completion
        mst_req = 3'b100;
        mst_wr  = '0;
        step();
        chk("R7 first activate", 32'(sd_a), 32'(row_of(2)));
        mst_req = 3'b001;
        tail(2, 1'b0, T);
        step();
        chk("R7 waiting request activates", 32'(pins), 32'(P_ACT));
        chk("R7 waiting request row", 32'(sd_a), 32'(row_of(0)));
        chk("R5 done cleared", 32'(mst_done), 32'd0);
        mst_req = '0;
        tail(0, 1'b0, T);
        step();

        // R8, R9: software command encodings and addresses
        sw_issue(4'd1, P_ACT,  13'h15A6, "R8 activate");
        sw_issue(4'd2, P_PREA, 13'h0400, "R8 precharge-all");
        sw_issue(4'd3, P_RD,   13'h01A6, "R8 read");
        sw_issue(4'd4, P_RD,   13'h05A6, "R8 read ap");
        sw_issue(4'd5, P_WR,   13'h01A6, "R8 write");
        sw_issue(4'd6, P_WR,   13'h05A6, "R8 write ap");
        sw_issue(4'd7, P_MRS,  13'h15A6, "R8 mode set");
        sw_issue(4'd8, P_BST,  13'h0000, "R8 burst stop");
        sw_issue(4'd9, P_REF,  13'h0000, "R8 refresh");

        // R12: codes with no action outside self refresh
        drop_code(4'd0);
        drop_code(4'd12);
        drop_code(4'd11);

        // R10: held command, replaced, issued before a waiting request
        mst_req = 3'b010;
        mst_wr  = '0;
        step();
        chk("R10 activate", 32'(pins), 32'(P_ACT));
        mst_req = 3'b001;
        sw_wr   = 1'b1;
        sw_code = 4'd8;
        step();
        chk("R10 gap NOP 1", 32'(pins), 32'(P_NOP));
        sw_code = 4'd9;
        step();
        chk("R10 gap NOP 2", 32'(pins), 32'(P_NOP));
        sw_wr = 1'b0;
        tail(1, 1'b0, T - 2);
        step();
        chk("R10 held refresh issued", 32'(pins), 32'(P_REF));
        chk("R10 busy during command", 32'(busy), 32'd1);
        step();
        chk("R10 NOP after held command", 32'(pins), 32'(P_NOP));
        step();
        chk("R10 waiting request after", 32'(pins), 32'(P_ACT));
        chk("R10 waiting row", 32'(sd_a), 32'(row_of(0)));
        mst_req = '0;
        tail(0, 1'b0, T);
        step();

        // R11, R12: self refresh entry, hold and exit
        sw_wr   = 1'b1;
        sw_code = 4'd10;
        step();
        sw_wr = 1'b0;
        chk("R11 entry pins", 32'(pins), 32'(P_SRE));
        step();
        chk("R11 hold pins", 32'(pins), 32'(P_SRH));
        chk("R11 busy in self refresh", 32'(busy), 32'd1);
        mst_req = 3'b001;
        sw_wr   = 1'b1;
        sw_code = 4'd9;
        step();
        sw_wr = 1'b0;
        chk("R12 other code dropped", 32'(pins), 32'(P_SRH));
        step();
        chk("R11 request not granted", 32'(pins), 32'(P_SRH));
        mst_req = '0;
        sw_wr   = 1'b1;
        sw_code = 4'd11;
        step();
        sw_wr = 1'b0;
        chk("R12 exit pins", 32'(pins), 32'(P_SRX));
        step();
        chk("R12 NOP after exit", 32'(pins), 32'(P_NOP));
        chk("R12 busy after exit", 32'(busy), 32'd0);
        step();
        chk("R12 dropped refresh left no trace", 32'(pins), 32'(P_NOP));

        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule